// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block decides which agents of a multi-agent system must receive an interrupt message. A requester presents an 8-bit destination, a physical/logical addressing flag, a 2-bit destination shorthand, the index of the sending agent and a lowest-priority flag. Every agent supplies a present bit, an 8-bit physical ID, an 8-bit logical ID and a 4-bit destination model. From these the block produces a bitmask with one bit per agent.

Logical addressing supports two matching models. Flat matching tests the destination and the logical ID for any shared set bit. Cluster matching compares the upper nibbles for equality and tests the lower nibbles for a shared set bit. Physical addressing selects a single agent by ID, or every agent when the broadcast destination is used. The shorthand can replace the addressed result with the sender alone, with every agent, or with every agent except the sender. In lowest-priority mode the mask is cut down to its lowest-indexed agent. No real priority arbitration takes place.

The result is computed combinationally and registered. It appears one cycle after a request strobe and is marked by a one-cycle valid pulse.

Top module: `ipi_dest_resolver`

## Requirements
- R1: With shorthand 2'd0 the mask is the addressed result given by the physical or logical rules (R5 to R9).
- R2: With shorthand 2'd1 the mask holds only the bit at the sender index `req_sender`.
- R3: With shorthand 2'd2 the mask holds every agent.
- R4: With shorthand 2'd3 the mask holds every agent except the one at the sender index.
- R5: In physical mode (`req_logical` = 0) a destination of 8'hFF selects every agent.
- R6: In physical mode with any other destination, only the lowest-indexed present agent whose physical ID equals the destination is selected. If no present agent has that ID, the mask is zero.
- R7: In logical mode (`req_logical` = 1) an agent with model 4'hF is selected when destination AND logical ID is nonzero.
- R8: In logical mode an agent with model 4'h0 is selected when the destination's bits [7:4] equal the logical ID's bits [7:4] and the two values share a set bit in bits [3:0].
- R9: In logical mode an agent with any model other than 4'hF or 4'h0 is never selected.
- R10: When `req_lowest` is 1, the final mask holds only the lowest-indexed bit of the mask that the other rules would give, or zero if that mask is empty.
- R11: An agent whose present bit is 0 is never selected, under any shorthand, broadcast or mode.
- R12: `out_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and `out_mask` then carries that request's result. An all-zero result is still flagged valid.
- R13: After reset `out_valid` is 0 and `out_mask` is zero. Between requests `out_mask` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | 0 addressed, 1 self, 2 all, 3 all but self |
| req_lowest | input | 1 | Lowest-priority reduction enable |
| req_sender | input | 5 | Index of the sending agent |
| agent_present | input | N_AGENTS | Per-agent present bits |
| agent_id | input | 8*N_AGENTS | Physical IDs, agent i at [8i+7:8i] |
| agent_logid | input | 8*N_AGENTS | Logical IDs, agent i at [8i+7:8i] |
| agent_model | input | 4*N_AGENTS | Destination models, agent i at [4i+3:4i] |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | N_AGENTS | Selected-agent bitmask |

## Verification
Every result is due exactly one clock edge after the edge that samples `req_valid`, because only one register stage separates the request from `out_mask` and `out_valid`. The bench drives each request on a falling edge and holds the strobe for one cycle. It then samples both outputs at the next falling edge, half a period after the capturing edge. One falling edge later it checks that `out_valid` has dropped and that the mask has held. The expected mask is taken from a bench function that applies the addressing rules and is computed when the request is driven.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;

    localparam int ID_W    = 8;
    localparam int MODEL_W = 4;

    localparam logic [ID_W-1:0]    DEST_BCAST    = 8'hFF;
    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [1:0] {
        SH_ADDRESSED = 2'd0,
        SH_SELF      = 2'd1,
        SH_ALL       = 2'd2,
        SH_OTHERS    = 2'd3
    } shorthand_e;

endpackage

// File: rtl/ipi_agent_match.sv
// Per-agent destination comparison for both addressing modes.
module ipi_agent_match
    import ipi_dest_pkg::*;
(
    input  logic [ID_W-1:0]    dest,
    input  logic               present,
    input  logic [ID_W-1:0]    phys_id,
    input  logic [ID_W-1:0]    log_id,
    input  logic [MODEL_W-1:0] model,
    output logic               phys_hit,
    output logic               log_hit
);
    logic flat_hit;
    logic cluster_hit;

    always_comb begin
        phys_hit    = present && (phys_id == dest);
        flat_hit    = (model == MODEL_FLAT) && ((dest & log_id) != '0);
        cluster_hit = (model == MODEL_CLUSTER)
                   && (dest[7:4] == log_id[7:4])
                   && ((dest[3:0] & log_id[3:0]) != 4'h0);
        log_hit     = present && (flat_hit || cluster_hit);
    end

endmodule

// File: rtl/ipi_first_set.sv
// Keeps only the lowest-indexed set bit of a vector.
module ipi_first_set #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec_in,
    output logic [WIDTH-1:0] vec_out
);
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign seen[i+1]  = seen[i] | vec_in[i];
        assign vec_out[i] = vec_in[i] & ~seen[i];
    end

endmodule

// File: rtl/ipi_shorthand_mask.sv
// Applies the destination shorthand to the addressed mask.
module ipi_shorthand_mask
    import ipi_dest_pkg::*;
#(
    parameter int N_AGENTS = 32,
    localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [1:0]          shorthand,
    input  logic [IDX_W-1:0]    sender,
    input  logic [N_AGENTS-1:0] addressed,
    output logic [N_AGENTS-1:0] mask
);
    logic [N_AGENTS-1:0] self_vec;

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_self
        assign self_vec[i] = (sender == IDX_W'(i));
    end

    always_comb begin
        unique case (shorthand_e'(shorthand))
            SH_ADDRESSED: mask = addressed;
            SH_SELF:      mask = self_vec;
            SH_ALL:       mask = '1;
            SH_OTHERS:    mask = ~self_vec;
            default:      mask = '0;
        endcase
    end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_dest_pkg::*;
#(
    parameter int N_AGENTS = 32,
    localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ID_W-1:0]             req_dest,
    input  logic                        req_logical,
    input  logic [1:0]                  req_shorthand,
    input  logic                        req_lowest,
    input  logic [IDX_W-1:0]            req_sender,
    input  logic [N_AGENTS-1:0]         agent_present,
    input  logic [N_AGENTS*ID_W-1:0]    agent_id,
    input  logic [N_AGENTS*ID_W-1:0]    agent_logid,
    input  logic [N_AGENTS*MODEL_W-1:0] agent_model,
    output logic                        out_valid,
    output logic [N_AGENTS-1:0]         out_mask
);
    typedef struct packed {
        logic                valid;
        logic [N_AGENTS-1:0] mask;
    } res_t;

    res_t res_d, res_q;

    logic [N_AGENTS-1:0] phys_hits;
    logic [N_AGENTS-1:0] log_hits;
    logic [N_AGENTS-1:0] phys_first;
    logic [N_AGENTS-1:0] addressed;
    logic [N_AGENTS-1:0] sh_mask;
    logic [N_AGENTS-1:0] gated;
    logic [N_AGENTS-1:0] gated_first;

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_lane
        ipi_agent_match u_match (
            .dest     (req_dest),
            .present  (agent_present[i]),
            .phys_id  (agent_id[i*ID_W +: ID_W]),
            .log_id   (agent_logid[i*ID_W +: ID_W]),
            .model    (agent_model[i*MODEL_W +: MODEL_W]),
            .phys_hit (phys_hits[i]),
            .log_hit  (log_hits[i])
        );
    end

    ipi_first_set #(.WIDTH(N_AGENTS)) u_phys_first (
        .vec_in  (phys_hits),
        .vec_out (phys_first)
    );

    always_comb begin
        if (req_logical) begin
            addressed = log_hits;
        end else if (req_dest == DEST_BCAST) begin
            addressed = agent_present;
        end else begin
            addressed = phys_first;
        end
    end

    ipi_shorthand_mask #(.N_AGENTS(N_AGENTS)) u_shorthand (
        .shorthand (req_shorthand),
        .sender    (req_sender),
        .addressed (addressed),
        .mask      (sh_mask)
    );

    assign gated = sh_mask & agent_present;

    ipi_first_set #(.WIDTH(N_AGENTS)) u_low_first (
        .vec_in  (gated),
        .vec_out (gated_first)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.mask = req_lowest ? gated_first : gated;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_mask  = res_q.mask;

endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk
    import ipi_dest_pkg::*;
#(
    parameter int N_AGENTS = 32,
    localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [ID_W-1:0]     req_dest,
    input logic                req_logical,
    input logic [1:0]          req_shorthand,
    input logic                req_lowest,
    input logic [N_AGENTS-1:0] agent_present,
    input logic                out_valid,
    input logic [N_AGENTS-1:0] out_mask
);
    // R12
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R12
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R13
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_mask));

    // R11
    absent_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((out_mask & ~$past(agent_present)) == '0));

    // R10
    lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lowest) |=> $onehot0(out_mask));

    // R2
    self_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_shorthand == 2'd1) |=> ($countones(out_mask) <= 1));

    // R6
    phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_shorthand == 2'd0 && !req_logical && req_dest != 8'hFF)
        |=> $onehot0(out_mask));

endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N_AGENTS(N_AGENTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_dest      (req_dest),
    .req_logical   (req_logical),
    .req_shorthand (req_shorthand),
    .req_lowest    (req_lowest),
    .agent_present (agent_present),
    .out_valid     (out_valid),
    .out_mask      (out_mask)
);

// File: tb/sim_ipi_dest_resolver.sv
module sim_ipi_dest_resolver;
    localparam int N  = 32;
    localparam int IW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [7:0]     req_dest = '0;
    logic           req_logical = 1'b0;
    logic [1:0]     req_shorthand = '0;
    logic           req_lowest = 1'b0;
    logic [IW-1:0]  req_sender = '0;
    logic [N-1:0]   agent_present = '0;
    logic [N*8-1:0] agent_id = '0;
    logic [N*8-1:0] agent_logid = '0;
    logic [N*4-1:0] agent_model = '0;
    logic           out_valid;
    logic [N-1:0]   out_mask;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ipi_dest_resolver #(.N_AGENTS(N)) u0 (
        .clk, .rst_n, .req_valid, .req_dest, .req_logical, .req_shorthand,
        .req_lowest, .req_sender, .agent_present, .agent_id, .agent_logid,
        .agent_model, .out_valid, .out_mask
    );

    function automatic logic [N-1:0] ref_mask();
        logic [N-1:0] a = '0;
        logic [N-1:0] r;
        logic [N-1:0] low = '0;
        if (!req_logical) begin
            if (req_dest == 8'hFF) a = agent_present;
            else for (int i = 0; i < N; i++)
                if (a == '0 && agent_present[i] && agent_id[i*8 +: 8] == req_dest) a[i] = 1'b1;
        end else begin
            for (int i = 0; i < N; i++) begin
                logic [7:0] l = agent_logid[i*8 +: 8];
                logic [3:0] m = agent_model[i*4 +: 4];
                if (m == 4'hF && (req_dest & l) != 0) a[i] = 1'b1;
                if (m == 4'h0 && req_dest[7:4] == l[7:4] && (req_dest[3:0] & l[3:0]) != 0) a[i] = 1'b1;
            end
        end
        case (req_shorthand)
            2'd0: r = a;
            2'd1: begin r = '0; r[req_sender] = 1'b1; end
            2'd2: r = '1;
            default: begin r = '1; r[req_sender] = 1'b0; end
        endcase
        r &= agent_present;
        if (req_lowest) begin
            for (int i = 0; i < N; i++)
                if (low == '0 && r[i]) low[i] = 1'b1;
            r = low;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(string tag);
        logic [N-1:0] exp;
        exp = ref_mask();
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R12 valid"}, N'(out_valid), N'(1));
        chk(tag, out_mask, exp);
        @(negedge clk);
        chk({tag, " R12 valid drop"}, N'(out_valid), N'(0));
        chk({tag, " R13 hold"}, out_mask, exp);
    endtask

    task automatic setup_agents();
        agent_present = '1;
        for (int i = 0; i < N; i++) begin
            agent_id[i*8 +: 8]    = 8'(i + 8'h10);
            agent_logid[i*8 +: 8] = 8'h00;
            agent_model[i*4 +: 4] = 4'hF;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        setup_agents();
        repeat (3) @(negedge clk);
        chk("R13 reset valid", N'(out_valid), N'(0));
        chk("R13 reset mask", out_mask, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // physical
        agent_present[6] = 1'b0;
        req_dest = 8'hFF; run("R5 broadcast R11 absent");
        req_dest = 8'h13; run("R6 id match");
        agent_id[9*8 +: 8] = 8'h13; agent_id[12*8 +: 8] = 8'h13;
        agent_id[3*8 +: 8] = 8'h00;
        run("R6 duplicate id lowest");
        req_dest = 8'hEE; run("R6 no match zero valid R12");
        setup_agents();
        // logical
        req_logical = 1'b1;
        agent_logid[2*8 +: 8] = 8'h05; agent_logid[7*8 +: 8] = 8'h40;
        req_dest = 8'h44; run("R7 flat");
        agent_model[2*4 +: 4] = 4'h0; agent_logid[2*8 +: 8] = 8'h32;
        agent_model[5*4 +: 4] = 4'h0; agent_logid[5*8 +: 8] = 8'h33;
        agent_model[8*4 +: 4] = 4'h0; agent_logid[8*8 +: 8] = 8'h22;
        agent_logid[7*8 +: 8] = 8'h00;
        req_dest = 8'h31; run("R8 cluster");
        agent_model[5*4 +: 4] = 4'h7; run("R9 other model");
        req_dest = 8'h00; run("R1 R7 zero dest");
        // shorthands
        req_logical = 1'b0; req_dest = 8'h20;
        req_sender = 5'd4; req_shorthand = 2'd1; run("R2 self");
        req_shorthand = 2'd2; run("R3 all");
        req_shorthand = 2'd3; run("R4 others");
        agent_present[4] = 1'b0; req_shorthand = 2'd1; run("R2 R11 absent sender");
        req_shorthand = 2'd3; req_lowest = 1'b1; req_sender = 5'd0; run("R10 lowest others");
        req_shorthand = 2'd0; req_logical = 1'b1; req_dest = 8'hFF; run("R10 lowest logical");
        req_lowest = 1'b0;

        for (int k = 0; k < 400; k++) begin
            agent_present = $urandom() | $urandom();
            for (int i = 0; i < N; i++) begin
                int sel = $urandom_range(0, 2);
                agent_id[i*8 +: 8]    = 8'($urandom_range(0, 15));
                agent_logid[i*8 +: 8] = 8'($urandom());
                agent_model[i*4 +: 4] = (sel == 0) ? 4'hF : (sel == 1) ? 4'h0 : 4'($urandom());
            end
            req_dest      = ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) req_dest = 8'($urandom());
            req_logical   = 1'($urandom());
            req_shorthand = ($urandom_range(0, 1) == 1) ? 2'd0 : 2'($urandom());
            req_lowest    = 1'($urandom());
            req_sender    = IW'($urandom());
            run("R1 R11 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule